// File: doc/BRIEF.md
# EtherType Admission Filter for an Unstoppable Stream

This block sits between a 512-bit packet stream that has no ready signal and a packet buffer. The source cannot be stalled, so every packet is either stored whole or thrown away whole. The block takes one keep-or-drop decision per packet, on its first beat. It keeps the packet only when two conditions hold. The first is that the EtherType in that beat equals a configured value. The second is that the buffer reports more free space, in beats, than one maximum-size packet needs.

Each packet starts at bit 0 of the bus, so the EtherType sits at a fixed byte position in the first beat. The decision holds for every beat up to and including the beat with tlast. A packet is therefore never partly written, even if the free space changes or a later beat carries a matching pattern. Two counters report how many packets were discarded for the wrong type and how many for lack of space.

Top module: `ethtype_admit_filter`

## Requirements
- R1: After reset, wr_en_o is 0 and both drop counters read 0.
- R2: The filter keeps a packet when two conditions hold on its first beat. The EtherType, made of byte 12 as the high byte and byte 13 as the low byte, equals ACCEPT_ETYPE (default 16'h888E), where byte n occupies bits 8n+7:8n. The free space free_beats_i is greater than MTU_BEATS. Every beat of a kept packet appears on the write port one clock after its input beat, with identical data, keep and last.
- R3: A packet with enough space whose first-beat EtherType differs from ACCEPT_ETYPE produces no write beat, and etype_drops_o increases by exactly 1.
- R4: A packet whose first beat sees free_beats_i less than or equal to MTU_BEATS produces no write beat, and space_drops_o increases by exactly 1. MTU_BEATS is the ceiling of MTU_BYTES/64 (default 1518 bytes gives 24). A packet that fails both checks counts only as a space drop.
- R5: The decision from the first beat governs every beat through tlast. Changes to free_beats_i, and the contents of bytes 12 and 13, in later beats of the same packet do not affect which beats are written.
- R6: A cycle with s_tvalid_i low produces no write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_tvalid_i | input | 1 | Input beat valid (no backpressure) |
| s_tdata_i | input | 512 | Input beat data, byte n at bits 8n+7:8n |
| s_tkeep_i | input | 64 | Input byte enables |
| s_tlast_i | input | 1 | Last beat of packet |
| free_beats_i | input | 16 | Free buffer space in beats |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_data_o | output | 512 | Buffer write data |
| wr_keep_o | output | 64 | Buffer write byte enables |
| wr_last_o | output | 1 | Buffer write end of packet |
| etype_drops_o | output | 16 | Packets dropped for EtherType mismatch |
| space_drops_o | output | 16 | Packets dropped for insufficient space |

## Verification
The hardest case to reach is a decision that must survive a change in its own inputs partway through a packet. The bench starts a kept packet with ample space and then drops free_beats_i to zero on the following beats. It also starts a dropped packet whose later beats carry the accepted EtherType in bytes 12 and 13. In both cases the bench checks each beat on the write port against the first-beat decision. Free space set exactly at MTU_BEATS and at one above it pins down the strict comparison.

// File: rtl/ethtype_admit_pkg.sv
package ethtype_admit_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned ETYPE_HI_BYTE = 12;
  localparam int unsigned ETYPE_LO_BYTE = 13;
  typedef logic [15:0] etype_t;
endpackage

// File: rtl/ethtype_extract.sv
module ethtype_extract
  import ethtype_admit_pkg::*;
#(
  parameter int unsigned DATA_W = 512
) (
  input  logic [DATA_W-1:0] data_i,
  output etype_t            etype_o
);
  assign etype_o = {data_i[ETYPE_HI_BYTE*BYTE_W +: BYTE_W],
                    data_i[ETYPE_LO_BYTE*BYTE_W +: BYTE_W]};
endmodule

// File: rtl/admit_decider.sv
module admit_decider
  import ethtype_admit_pkg::*;
#(
  parameter int unsigned FREE_W       = 16,
  parameter int unsigned MTU_BEATS    = 24,
  parameter etype_t      ACCEPT_ETYPE = 16'h888E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              last_i,
  input  etype_t            etype_i,
  input  logic [FREE_W-1:0] free_i,
  output logic              pass_o,
  output logic              drop_etype_o,
  output logic              drop_space_o
);
  logic in_pkt_q, keep_q;
  logic sop, space_ok, type_ok, keep_now;

  assign sop      = valid_i && !in_pkt_q;
  assign space_ok = free_i > FREE_W'(MTU_BEATS);
  assign type_ok  = etype_i == ACCEPT_ETYPE;
  assign keep_now = space_ok && type_ok;

  assign pass_o       = valid_i && (sop ? keep_now : keep_q);
  assign drop_space_o = sop && !space_ok;
  assign drop_etype_o = sop && space_ok && !type_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      keep_q   <= 1'b0;
    end else if (valid_i) begin
      in_pkt_q <= !last_i;
      if (sop) keep_q <= keep_now;
    end
  end
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ethtype_admit_filter.sv
module ethtype_admit_filter
  import ethtype_admit_pkg::*;
#(
  parameter int unsigned DATA_W       = 512,
  parameter int unsigned FREE_W       = 16,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned MTU_BYTES    = 1518,
  parameter etype_t      ACCEPT_ETYPE = 16'h888E,
  localparam int unsigned KEEP_W      = DATA_W / 8,
  localparam int unsigned MTU_BEATS   = (MTU_BYTES + KEEP_W - 1) / KEEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_tvalid_i,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic [KEEP_W-1:0] s_tkeep_i,
  input  logic              s_tlast_i,
  input  logic [FREE_W-1:0] free_beats_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [KEEP_W-1:0] wr_keep_o,
  output logic              wr_last_o,
  output logic [CNT_W-1:0]  etype_drops_o,
  output logic [CNT_W-1:0]  space_drops_o
);
  etype_t etype;
  logic   pass, drop_etype, drop_space;
  logic [1:0]           drop_inc;
  logic [1:0][CNT_W-1:0] drop_cnt;

  ethtype_extract #(.DATA_W(DATA_W)) u_extract (
    .data_i (s_tdata_i),
    .etype_o(etype)
  );

  admit_decider #(
    .FREE_W(FREE_W), .MTU_BEATS(MTU_BEATS), .ACCEPT_ETYPE(ACCEPT_ETYPE)
  ) u_decider (
    .clk_i, .rst_ni,
    .valid_i     (s_tvalid_i),
    .last_i      (s_tlast_i),
    .etype_i     (etype),
    .free_i      (free_beats_i),
    .pass_o      (pass),
    .drop_etype_o(drop_etype),
    .drop_space_o(drop_space)
  );

  assign drop_inc = {drop_space, drop_etype};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    drop_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i(drop_inc[g]),
      .cnt_o(drop_cnt[g])
    );
  end

  assign etype_drops_o = drop_cnt[0];
  assign space_drops_o = drop_cnt[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_en_o <= 1'b0;
    else         wr_en_o <= pass;
  end

  // data path needs no reset; qualified by wr_en_o
  always_ff @(posedge clk_i) begin
    if (pass) begin
      wr_data_o <= s_tdata_i;
      wr_keep_o <= s_tkeep_i;
      wr_last_o <= s_tlast_i;
    end
  end
endmodule

// File: rtl/ethtype_admit_filter_chk.sv
module ethtype_admit_filter_chk #(
  parameter int unsigned DATA_W    = 512,
  parameter int unsigned KEEP_W    = 64,
  parameter int unsigned FREE_W    = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MTU_BEATS = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_tvalid_i,
  input logic [DATA_W-1:0] s_tdata_i,
  input logic [KEEP_W-1:0] s_tkeep_i,
  input logic              s_tlast_i,
  input logic [FREE_W-1:0] free_beats_i,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [KEEP_W-1:0] wr_keep_o,
  input logic              wr_last_o,
  input logic [CNT_W-1:0]  etype_drops_o,
  input logic [CNT_W-1:0]  space_drops_o
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !wr_en_o);

  assert_write_copies_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o == $past(s_tdata_i)) && (wr_keep_o == $past(s_tkeep_i))
                && (wr_last_o == $past(s_tlast_i)));

  assert_one_drop_reason_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({etype_drops_o != $past(etype_drops_o),
                space_drops_o != $past(space_drops_o)}) <= 1);

  assert_space_drop_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (space_drops_o != $past(space_drops_o)) |-> ($past(free_beats_i) <= FREE_W'(MTU_BEATS)));

  assert_kept_packet_continues_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_last_o) |=> ($past(s_tvalid_i) == wr_en_o));

  assert_no_write_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_tvalid_i |=> !wr_en_o);
endmodule

bind ethtype_admit_filter ethtype_admit_filter_chk #(
  .DATA_W(DATA_W), .KEEP_W(KEEP_W), .FREE_W(FREE_W), .CNT_W(CNT_W), .MTU_BEATS(MTU_BEATS)
) u_chk (.*);

// File: tb/ethtype_admit_filter_tb_top.sv
module ethtype_admit_filter_tb_top;
  localparam int DW = 512;
  localparam int KW = 64;
  localparam int MTU_B = 24;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          vld = 0;
  logic [DW-1:0] dat = '0;
  logic [KW-1:0] kp = '0;
  logic          lst = 0;
  logic [15:0]   free = '0;
  logic          wr_en, wr_last;
  logic [DW-1:0] wr_data;
  logic [KW-1:0] wr_keep;
  logic [15:0]   et_drops, sp_drops;

  int checks = 0, fails = 0;
  int exp_et = 0, exp_sp = 0;

  always #2.5 clk = ~clk;

  ethtype_admit_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .s_tvalid_i(vld), .s_tdata_i(dat), .s_tkeep_i(kp),
    .s_tlast_i(lst), .free_beats_i(free), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .wr_keep_o(wr_keep), .wr_last_o(wr_last), .etype_drops_o(et_drops),
    .space_drops_o(sp_drops)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vectors: etype, free at sop, beats, expected keep
  localparam int NV = 7;
  localparam logic [15:0] V_ET   [NV] = '{16'h888E, 16'h0800, 16'h888E, 16'h888E, 16'h0800, 16'h8E88, 16'h888E};
  localparam int          V_FREE [NV] = '{100, 100, MTU_B, MTU_B + 1, 5, 100, 0};
  localparam int          V_LEN  [NV] = '{3, 2, 2, 1, 2, 1, 4};
  localparam bit          V_KEEP [NV] = '{1, 0, 0, 1, 0, 0, 0};

  // free_late: free value for beats after the first
  task automatic send_pkt(input int id, input logic [15:0] et, input int free0,
                          input int free_late, input int len, input bit keep,
                          input string req);
    for (int b = 0; b < len; b++) begin
      logic [DW-1:0] d;
      d = {16{32'(id * 256 + b)}};
      // later beats carry the accepted type in bytes 12/13 to show it is ignored
      d[12*8 +: 8] = (b == 0) ? et[15:8] : 8'h88;
      d[13*8 +: 8] = (b == 0) ? et[7:0]  : 8'h8E;
      vld  = 1;
      dat  = d;
      kp   = (b == len - 1) ? 64'h0000_0000_FFFF_FFFF : '1;
      lst  = (b == len - 1);
      free = 16'((b == 0) ? free0 : free_late);
      @(posedge clk); #1;
      chk(req, 64'(wr_en), 64'(keep));
      if (keep) begin
        chk({req, " data"}, wr_data[63:0], d[63:0]);
        chk({req, " last"}, 64'(wr_last), 64'(b == len - 1));
        chk({req, " keep"}, wr_keep, kp);
      end
    end
    vld = 0; lst = 0;
    @(posedge clk); #1;
    chk("R6 idle after packet", 64'(wr_en), 64'd0);
  endtask

  initial begin
    #1;
    chk("R1 reset wr_en", 64'(wr_en), 64'd0);
    chk("R1 reset etype_drops", 64'(et_drops), 64'd0);
    chk("R1 reset space_drops", 64'(sp_drops), 64'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R6 no valid no write", 64'(wr_en), 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (V_FREE[i] <= MTU_B) exp_sp++;
      else if (V_ET[i] != 16'h888E) exp_et++;
      send_pkt(i, V_ET[i], V_FREE[i], V_FREE[i], V_LEN[i], V_KEEP[i],
               V_KEEP[i] ? "R2 kept packet" : (V_FREE[i] <= MTU_B ? "R4 space drop" : "R3 type drop"));
      chk("R3 etype_drops count", 64'(et_drops), 64'(exp_et));
      chk("R4 space_drops count", 64'(sp_drops), 64'(exp_sp));
    end

    // kept packet whose free space collapses after the first beat
    send_pkt(20, 16'h888E, 200, 0, 4, 1'b1, "R5 kept despite later free=0");
    chk("R5 no space drop counted", 64'(sp_drops), 64'(exp_sp));

    // dropped packet whose later beats carry 0x888E and plenty of space
    exp_et++;
    send_pkt(21, 16'h86DD, 200, 200, 3, 1'b0, "R5 dropped despite later match");
    chk("R5 etype_drops count", 64'(et_drops), 64'(exp_et));

    // back-to-back packets: second must be re-decided at its own first beat
    exp_sp++;
    send_pkt(22, 16'h888E, 10, 10, 2, 1'b0, "R4 space drop back-to-back");
    send_pkt(23, 16'h888E, 30, 30, 2, 1'b1, "R2 kept after drop");
    chk("R4 space_drops final", 64'(sp_drops), 64'(exp_sp));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule